// File: doc/BRIEF.md
# Exception Context Save/Restore Sequencer

This block moves a core's caller-saved context between its register file and a full-descending stack in memory. A save request pushes a fixed eight-word frame below the supplied stack pointer, one word per memory transaction, and then hands back the lowered stack pointer. A restore request pulls the same eight words back from the supplied frame base and hands back the raised stack pointer.

The block is started with a one-cycle request. The core supplies the current stack pointer and, for a save, all eight register values on a flat bus. The memory side is a word-wide request/ready port: the request holds steady until the memory answers with ready, and an error flag returned with ready ends the sequence. A one-cycle done pulse, with a stack-pointer load strobe, reports completion. A one-cycle err pulse reports an abort.

Top module: `ctx_frame_seq`

## Requirements
- R1: While reset is applied, and after it until the first request, busy, mem_req, done, err and sp_load are all low.
- R2: The frame is eight 32-bit slots. Slot k sits at byte offset 4*k above the new stack pointer and holds reg_in bits [32k+31:32k]. By slot, the registers are R0, R1, R2, R3, R12, LR, PC and PSR for k = 0 to 7. A save writes slot 7 first and slot 0 last, so the addresses are sp_in-4, sp_in-8, down to sp_in-0x20.
- R3: In the cycle after a save's eighth accepted write, done and sp_load are high for one cycle and sp_out equals sp_in-0x20. sp_out keeps that value afterwards.
- R4: A restore reads slot 0 first and slot 7 last, at addresses sp_in, sp_in+4, up to sp_in+0x1C. The word read from slot k appears on reg_out bits [32k+31:32k].
- R5: In the cycle after a restore's eighth accepted read, done and sp_load are high for one cycle, sp_out equals sp_in+0x20, and reg_out holds all eight words.
- R6: A memory request keeps mem_req, mem_addr, mem_we and mem_wdata steady until mem_ready is seen high at a clock edge. Exactly one word moves per accepted edge, whatever the number of wait cycles.
- R7: When mem_ready and mem_err are both high at an edge, the sequence stops. In the next cycle err is high for one cycle, busy is low, no further request is made, done and sp_load stay low, and sp_out keeps its previous value.
- R8: busy rises in the cycle after a request is taken and falls in the same cycle that done or err rises. A save_req or restore_req while busy is ignored.
- R9: If save_req and restore_req are high in the same idle cycle, the save is performed.
- R10: mem_we is high for every save transaction and low for every restore transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_req | input | 1 | Start a save (push) sequence |
| restore_req | input | 1 | Start a restore (pop) sequence |
| sp_in | input | 32 | Current stack pointer at the request |
| reg_in | input | 256 | Eight register values, slot k in bits [32k+31:32k] |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Transaction accepted this edge |
| mem_err | input | 1 | Error response, valid with mem_ready |
| reg_out | output | 256 | Restored register values, slot k in bits [32k+31:32k] |
| sp_out | output | 32 | Stack pointer after the last completed sequence |
| sp_load | output | 1 | One-cycle strobe: load sp_out into the stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle abort pulse |

## Verification
A slot index that steps the wrong way, or by the wrong amount, shows on mem_addr at the very next accepted transaction. The bench also catches it later, once the memory model's image of the frame no longer matches reg_in slot for slot. A wrong frame base shows on the first request address and again in sp_out in the cycle after the final beat. A controller that misses its end condition, or its abort, leaves busy high and keeps issuing requests after the eighth beat or after an error. That is visible on mem_req within one cycle, and in the transaction count before the next scenario starts.

// File: rtl/ctx_frame_pkg.sv
package ctx_frame_pkg;

  localparam int unsigned CF_ADDR_W      = 32;
  localparam int unsigned CF_WORD_W      = 32;
  localparam int unsigned CF_FRAME_WORDS = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_POP  = 2'd2
  } seq_state_e;

  // Byte distance of a slot from the frame base.
  function automatic int unsigned slot_offset(input int unsigned idx,
                                              input int unsigned step);
    return idx * step;
  endfunction

  // Total byte size of the frame: the stack pointer moves by this much.
  function automatic int unsigned frame_bytes(input int unsigned words,
                                              input int unsigned step);
    return words * step;
  endfunction

endpackage

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
  import ctx_frame_pkg::*;
#(
  parameter int unsigned ADDR_W      = CF_ADDR_W,
  parameter int unsigned FRAME_WORDS = CF_FRAME_WORDS,
  parameter int unsigned WORD_BYTES  = CF_WORD_W / 8,
  parameter int unsigned IDX_W       = $clog2(FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_req,
  input  logic              restore_req,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic              beat_ok,
  input  logic              beat_bad,
  output seq_state_e        state,
  output logic [IDX_W-1:0]  slot_idx,
  output logic [ADDR_W-1:0] base,
  output logic              final_beat,
  output logic              start_fire,
  output logic              push_start,
  output logic              done,
  output logic              err,
  output logic              sp_load,
  output logic [ADDR_W-1:0] sp_out
);

  localparam logic [ADDR_W-1:0] SPAN     = ADDR_W'(frame_bytes(FRAME_WORDS, WORD_BYTES));
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(FRAME_WORDS - 1);
  localparam logic [IDX_W-1:0]  ONE      = IDX_W'(1);

  assign start_fire = (state == ST_IDLE) && (save_req || restore_req);
  assign push_start = (state == ST_IDLE) && save_req;
  assign final_beat = (state == ST_PUSH) ? (slot_idx == '0) : (slot_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      slot_idx <= '0;
      base     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      sp_load  <= 1'b0;
      sp_out   <= '0;
    end else begin
      done    <= 1'b0;
      err     <= 1'b0;
      sp_load <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (save_req) begin
            state    <= ST_PUSH;
            base     <= sp_in - SPAN;
            slot_idx <= LAST_IDX;
          end else if (restore_req) begin
            state    <= ST_POP;
            base     <= sp_in;
            slot_idx <= '0;
          end
        end
        default: begin
          if (beat_bad) begin
            state <= ST_IDLE;
            err   <= 1'b1;
          end else if (beat_ok) begin
            if (final_beat) begin
              state   <= ST_IDLE;
              done    <= 1'b1;
              sp_load <= 1'b1;
              sp_out  <= (state == ST_PUSH) ? base : base + SPAN;
            end else if (state == ST_PUSH) begin
              slot_idx <= slot_idx - ONE;
            end else begin
              slot_idx <= slot_idx + ONE;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/ctx_save_latch.sv
module ctx_save_latch
  import ctx_frame_pkg::*;
#(
  parameter int unsigned WORD_W      = CF_WORD_W,
  parameter int unsigned FRAME_WORDS = CF_FRAME_WORDS,
  parameter int unsigned IDX_W       = $clog2(FRAME_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [FRAME_WORDS*WORD_W-1:0] frame_in,
  input  logic [IDX_W-1:0]              slot_idx,
  output logic [WORD_W-1:0]             word_out
);

  logic [WORD_W-1:0] held [FRAME_WORDS];

  for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held[g] <= '0;
      else if (load) held[g] <= frame_in[g*WORD_W +: WORD_W];
    end
  end

  assign word_out = held[slot_idx];

endmodule

// File: rtl/ctx_restore_bank.sv
module ctx_restore_bank
  import ctx_frame_pkg::*;
#(
  parameter int unsigned WORD_W      = CF_WORD_W,
  parameter int unsigned FRAME_WORDS = CF_FRAME_WORDS,
  parameter int unsigned IDX_W       = $clog2(FRAME_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          capture,
  input  logic [IDX_W-1:0]              slot_idx,
  input  logic [WORD_W-1:0]             word_in,
  output logic [FRAME_WORDS*WORD_W-1:0] frame_out
);

  for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_slot
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   q <= '0;
      else if (capture && (slot_idx == IDX_W'(g)))  q <= word_in;
    end
    assign frame_out[g*WORD_W +: WORD_W] = q;
  end

endmodule

// File: rtl/ctx_frame_seq.sv
module ctx_frame_seq
  import ctx_frame_pkg::*;
#(
  parameter int unsigned ADDR_W      = CF_ADDR_W,
  parameter int unsigned WORD_W      = CF_WORD_W,
  parameter int unsigned FRAME_WORDS = CF_FRAME_WORDS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          save_req,
  input  logic                          restore_req,
  input  logic [ADDR_W-1:0]             sp_in,
  input  logic [FRAME_WORDS*WORD_W-1:0] reg_in,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [WORD_W-1:0]             mem_wdata,
  input  logic [WORD_W-1:0]             mem_rdata,
  input  logic                          mem_ready,
  input  logic                          mem_err,
  output logic [FRAME_WORDS*WORD_W-1:0] reg_out,
  output logic [ADDR_W-1:0]             sp_out,
  output logic                          sp_load,
  output logic                          busy,
  output logic                          done,
  output logic                          err
);

  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned IDX_W      = $clog2(FRAME_WORDS);

  seq_state_e         state;
  logic [IDX_W-1:0]   slot_idx;
  logic [ADDR_W-1:0]  base;
  logic               final_beat;
  logic               start_fire;
  logic               push_start;
  logic               beat_ok;
  logic               beat_bad;
  logic               pop_capture;

  // Named events for the checker.
  assign beat_ok     = mem_req && mem_ready && !mem_err;
  assign beat_bad    = mem_req && mem_ready && mem_err;
  assign pop_capture = beat_ok && (state == ST_POP);

  ctx_seq_ctrl #(
    .ADDR_W      (ADDR_W),
    .FRAME_WORDS (FRAME_WORDS),
    .WORD_BYTES  (WORD_BYTES),
    .IDX_W       (IDX_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .sp_in       (sp_in),
    .beat_ok     (beat_ok),
    .beat_bad    (beat_bad),
    .state       (state),
    .slot_idx    (slot_idx),
    .base        (base),
    .final_beat  (final_beat),
    .start_fire  (start_fire),
    .push_start  (push_start),
    .done        (done),
    .err         (err),
    .sp_load     (sp_load),
    .sp_out      (sp_out)
  );

  ctx_save_latch #(
    .WORD_W      (WORD_W),
    .FRAME_WORDS (FRAME_WORDS),
    .IDX_W       (IDX_W)
  ) u_save (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (push_start),
    .frame_in (reg_in),
    .slot_idx (slot_idx),
    .word_out (mem_wdata)
  );

  ctx_restore_bank #(
    .WORD_W      (WORD_W),
    .FRAME_WORDS (FRAME_WORDS),
    .IDX_W       (IDX_W)
  ) u_restore (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (pop_capture),
    .slot_idx  (slot_idx),
    .word_in   (mem_rdata),
    .frame_out (reg_out)
  );

  assign busy     = (state != ST_IDLE);
  assign mem_req  = busy;
  assign mem_we   = (state == ST_PUSH);
  assign mem_addr = base + ADDR_W'(slot_offset(32'(slot_idx), WORD_BYTES));

endmodule

// File: rtl/ctx_frame_seq_chk.sv
module ctx_frame_seq_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              save_req,
  input logic              start_fire,
  input logic              beat_ok,
  input logic              beat_bad,
  input logic              final_beat,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              sp_load,
  input logic [ADDR_W-1:0] sp_in,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] sp_out,
  input logic [WORD_W-1:0] mem_wdata
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r6_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  a_r2_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ok && mem_we && !final_beat |=> mem_req && mem_we && (mem_addr == $past(mem_addr) - STEP));

  a_r4_pop_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ok && !mem_we && !final_beat |=> mem_req && !mem_we && (mem_addr == $past(mem_addr) + STEP));

  a_r9_push_first: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire && save_req |=> mem_req && mem_we && (mem_addr == $past(sp_in) - STEP));

  a_r4_pop_first: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire && !save_req |=> mem_req && !mem_we && (mem_addr == $past(sp_in)));

  a_r3_push_sp: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ok && final_beat && mem_we |=> done && sp_load && !busy && (sp_out == $past(mem_addr)));

  a_r5_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
    beat_ok && final_beat && !mem_we |=> done && sp_load && !busy && (sp_out == $past(mem_addr) + STEP));

  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    beat_bad |=> err && !done && !sp_load && !busy && $stable(sp_out));

  a_r8_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    done || err |=> !done && !err);

endmodule

bind ctx_frame_seq ctx_frame_seq_chk #(
  .ADDR_W (ADDR_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .save_req   (save_req),
  .start_fire (start_fire),
  .beat_ok    (beat_ok),
  .beat_bad   (beat_bad),
  .final_beat (final_beat),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ready  (mem_ready),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .sp_load    (sp_load),
  .sp_in      (sp_in),
  .mem_addr   (mem_addr),
  .sp_out     (sp_out),
  .mem_wdata  (mem_wdata)
);

// File: tb/ctx_frame_seq_bench.sv
`timescale 1ns/1ps
module ctx_frame_seq_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         save_req = 1'b0;
  logic         restore_req = 1'b0;
  logic [31:0]  sp_in = '0;
  logic [255:0] reg_in = '0;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr, mem_wdata;
  logic [31:0]  mem_rdata;
  logic         mem_ready, mem_err;
  logic [255:0] reg_out;
  logic [31:0]  sp_out;
  logic         sp_load, busy, done, err;

  always #4 clk = ~clk;

  ctx_frame_seq u_ctx_frame_seq (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .sp_in(sp_in), .reg_in(reg_in), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .mem_err(mem_err), .reg_out(reg_out),
    .sp_out(sp_out), .sp_load(sp_load), .busy(busy), .done(done), .err(err)
  );

  int vectors = 0;
  int fails = 0;

  // Memory model state
  logic [31:0] mem [64];
  logic [31:0] txn_addr [16];
  logic        txn_we [16];
  int          txn_cnt = 0;
  int          wait_cnt = 0;
  int          cfg_wait = 0;
  int          cfg_err_at = -1;

  // Results of the last sequence
  logic        r_done, r_err, r_sp_load, r_busy_ok, r_pulse_ok;
  logic [31:0] r_sp_out;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem_ready = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ready = 1'b0; mem_err = 1'b0;
      if (rst_n && mem_req) begin
        if (wait_cnt < cfg_wait) wait_cnt++;
        else begin
          wait_cnt  = 0;
          mem_ready = 1'b1;
          if (txn_cnt == cfg_err_at) mem_err = 1'b1;
          else if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
          mem_rdata = mem_we ? 32'h0 : mem[mem_addr[7:2]];
          if (txn_cnt < 16) begin
            txn_addr[txn_cnt] = mem_addr;
            txn_we[txn_cnt]   = mem_we;
          end
          txn_cnt++;
        end
      end
    end
  end

  function automatic logic [255:0] make_regs(input logic [31:0] seed);
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = seed + 32'(k) * 32'h0101_0101;
    return v;
  endfunction

  // Drives one request and waits for done or err. poke_at >= 0 raises
  // restore_req for one cycle at that point while busy.
  task automatic run_seq(input bit do_save, input bit both, input logic [31:0] sp,
                         input logic [255:0] regs, input int wt, input int err_at,
                         input int poke_at);
    int n;
    cfg_wait = wt; cfg_err_at = err_at; txn_cnt = 0; wait_cnt = 0;
    save_req = do_save || both; restore_req = !do_save || both;
    sp_in = sp; reg_in = regs;
    @(negedge clk);
    save_req = 1'b0; restore_req = 1'b0;
    r_busy_ok = 1'b1; n = 0;
    while (!(done || err) && n < 500) begin
      if (!busy) r_busy_ok = 1'b0;
      if (n == poke_at) begin restore_req = 1'b1; sp_in = 32'h2000_0000; end
      else restore_req = 1'b0;
      @(negedge clk);
      n++;
    end
    restore_req = 1'b0;
    r_done = done; r_err = err; r_sp_load = sp_load; r_sp_out = sp_out;
    if (busy) r_busy_ok = 1'b0;
    @(negedge clk);
    r_pulse_ok = !done && !err && !sp_load;
  endtask

  task automatic check_push_txns(input logic [31:0] sp, input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < 8; i++)
      if (txn_addr[i] != sp - 32'(4*(i+1)) || !txn_we[i]) ok = 1'b0;
    chk(ok, {tag, " R2 R10 write order/addresses"}, txn_addr[0], sp - 32'h4);
    chk(txn_cnt == 8, {tag, " R6 one word per beat"}, 32'(txn_cnt), 32'd8);
  endtask

  task automatic check_frame_image(input logic [31:0] nsp, input logic [255:0] regs, input string tag);
    bit ok = 1'b1;
    for (int k = 0; k < 8; k++)
      if (mem[(nsp[7:2] + 6'(k))] != regs[k*32 +: 32]) ok = 1'b0;
    chk(ok, {tag, " R2 slot contents"}, mem[nsp[7:2]], regs[31:0]);
  endtask

  task automatic t_reset();
    chk(!busy && !mem_req && !done && !err && !sp_load, "R1 reset outputs",
        {27'd0, busy, mem_req, done, err, sp_load}, 32'd0);
  endtask

  task automatic t_save(input logic [31:0] sp, input logic [31:0] seed, input int wt, input string tag);
    logic [255:0] regs = make_regs(seed);
    run_seq(1'b1, 1'b0, sp, regs, wt, -1, -1);
    check_push_txns(sp, tag);
    check_frame_image(sp - 32'h20, regs, tag);
    chk(r_done && r_sp_load && !r_err, {tag, " R3 done with sp_load"}, {30'd0, r_done, r_sp_load}, 32'd3);
    chk(r_sp_out == sp - 32'h20, {tag, " R3 new sp"}, r_sp_out, sp - 32'h20);
    chk(r_busy_ok && r_pulse_ok, {tag, " R8 busy window and pulse"}, {30'd0, r_busy_ok, r_pulse_ok}, 32'd3);
    chk(sp_out == sp - 32'h20, {tag, " R3 sp_out held"}, sp_out, sp - 32'h20);
  endtask

  task automatic t_restore(input logic [31:0] sp, input int wt);
    bit ok = 1'b1;
    bit rok = 1'b1;
    for (int k = 0; k < 8; k++) mem[sp[7:2] + 6'(k)] = 32'hC0DE_0000 + 32'(k * 17);
    run_seq(1'b0, 1'b0, sp, '0, wt, -1, -1);
    for (int i = 0; i < 8; i++)
      if (txn_addr[i] != sp + 32'(4*i) || txn_we[i]) ok = 1'b0;
    chk(ok && txn_cnt == 8, "R4 R10 read order/addresses", txn_addr[0], sp);
    for (int k = 0; k < 8; k++)
      if (reg_out[k*32 +: 32] != 32'hC0DE_0000 + 32'(k * 17)) rok = 1'b0;
    chk(rok, "R5 reg_out slots", reg_out[255:224], 32'hC0DE_0000 + 32'd119);
    chk(r_done && r_sp_load && !r_err, "R5 done with sp_load", {30'd0, r_done, r_sp_load}, 32'd3);
    chk(r_sp_out == sp + 32'h20, "R5 new sp", r_sp_out, sp + 32'h20);
    chk(r_busy_ok && r_pulse_ok, "R8 restore busy window", {30'd0, r_busy_ok, r_pulse_ok}, 32'd3);
  endtask

  task automatic t_roundtrip();
    logic [255:0] regs = make_regs(32'h5A00_1234);
    run_seq(1'b1, 1'b0, 32'h2000_00C0, regs, 1, -1, -1);
    run_seq(1'b0, 1'b0, r_sp_out, '0, 0, -1, -1);
    chk(reg_out == regs, "R2 R4 round trip restores frame", reg_out[31:0], regs[31:0]);
    chk(r_sp_out == 32'h2000_00C0, "R5 round trip sp", r_sp_out, 32'h2000_00C0);
  endtask

  task automatic t_ignore_busy();
    run_seq(1'b1, 1'b0, 32'h2000_0080, make_regs(32'h7700_0000), 1, -1, 3);
    repeat (4) @(negedge clk);
    chk(txn_cnt == 8, "R8 start while busy ignored (count)", 32'(txn_cnt), 32'd8);
    chk(!busy && !mem_req, "R8 idle after ignored start", {30'd0, busy, mem_req}, 32'd0);
    chk(r_sp_out == 32'h2000_0060, "R8 sp unaffected by ignored start", r_sp_out, 32'h2000_0060);
  endtask

  task automatic t_err(input bit do_save, input int at, input string tag);
    logic [31:0] prior = sp_out;
    run_seq(do_save, 1'b0, 32'h2000_0080, make_regs(32'h1111_0000), 0, at, -1);
    chk(r_err && !r_done && !r_sp_load, {tag, " R7 err without done"}, {29'd0, r_err, r_done, r_sp_load}, 32'd4);
    chk(r_sp_out == prior, {tag, " R7 sp unchanged"}, r_sp_out, prior);
    chk(r_busy_ok && r_pulse_ok, {tag, " R8 busy falls with err"}, {30'd0, r_busy_ok, r_pulse_ok}, 32'd3);
    repeat (3) @(negedge clk);
    chk(txn_cnt == at + 1 && !mem_req, {tag, " R7 no further request"}, 32'(txn_cnt), 32'(at + 1));
  endtask

  task automatic t_both();
    run_seq(1'b1, 1'b1, 32'h2000_0040, make_regs(32'h0BAD_0000), 0, -1, -1);
    check_push_txns(32'h2000_0040, "R9 both requests");
    chk(r_sp_out == 32'h2000_0020, "R9 save wins sp", r_sp_out, 32'h2000_0020);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_save(32'h2000_0080, 32'hA0A0_0001, 0, "save w0");
    t_save(32'h2000_0040, 32'h3C00_0100, 2, "save w2 R6");
    t_restore(32'h2000_0040, 1);
    t_roundtrip();
    t_ignore_busy();
    t_err(1'b1, 3, "save abort");
    t_err(1'b0, 0, "restore abort");
    t_both();
    finish_run();
  end

endmodule